// File: doc/BRIEF.md
# Unified Address Translation Lookaside Buffer

This block translates 32-bit virtual addresses to physical addresses through a 64-entry fully associative table. Each entry describes one page of 1 KB, 4 KB, 64 KB or 1 MB, tagged with an 8-bit address-space identifier (ASID) unless it is marked as shared. It carries a two-bit access-permission field, a dirty flag, and cacheable and write-through attributes. A lookup is presented for one cycle on a request strobe together with the access kind (read, write or instruction fetch), the current ASID, the privilege level and the single-virtual-space mode bit. One cycle later the block returns the physical address, whether a single entry matched and which one, the entry's cache attributes, and a fault code.

Refills are written by software through an entry write port. The written entry lands in the slot named by a replacement counter. The counter advances once per lookup and wraps at a software-supplied boundary, or at the top of the table when the boundary is zero. An invalidate-all input clears every entry's valid flag in one cycle.

Top module: `unifiedTlb`

## Requirements
- R1: An entry matches a lookup when it is valid and the virtual address falls inside its page. The page holds 1 KB, 4 KB, 64 KB or 1 MB for size codes 0, 1, 2 and 3, and the entry's VPN is virtual address bits [31:10]. Address bits below the page size are ignored in the compare.
- R2: The entry's ASID must equal `curAsid` unless the entry is shared, or unless `singleVirt` and `privMode` are both 1. In that last case the ASID is not compared.
- R3: On a lookup with no fault, `rspPaddr` holds the entry's PPN placed at bits [31:10], with the in-page bits replaced by the virtual address's in-page bits. On any fault, `rspPaddr`, `rspCacheable` and `rspWriteThru` are 0.
- R4: When two or more entries match, `rspFault` is 4 (multi-hit) and `rspHit` is 0.
- R5: When no entry matches, `rspHit` is 0 and `rspFault` is 1 for a read, 2 for a write and 3 for a fetch. `reqKind` is 0 for read, 1 for write and 2 for fetch; 3 is treated as read.
- R6: On a single match with `privMode` 0 and permission bit 1 clear, `rspFault` is 5 for a read, 6 for a write and 7 for a fetch.
- R7: Otherwise, a write to an entry whose permission bit 0 is clear gives `rspFault` 6, in either privilege level.
- R8: Otherwise, a write to an entry whose dirty flag is clear gives `rspFault` 8 (first write to a clean page). All other single matches give fault 0.
- R9: `replIdx` resets to 0 and advances by one on each lookup. It wraps to 0 when the advanced value would exceed a nonzero `replBound`, or would exceed 63. It holds when there is no lookup.
- R10: An entry write stores all fields at the slot `replIdx` holds in that cycle. A matching lookup then reports that slot on `rspIndex` with `rspHit` 1.
- R11: `invalAll` clears every valid flag, so any lookup issued afterwards misses until new entries are written.
- R12: Lookup results appear, with `rspValid` high, in the cycle after the request strobe. A lookup made in the same cycle as an entry write sees the table as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Virtual address to translate |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| curAsid | input | 8 | Current address-space identifier |
| privMode | input | 1 | 1 for privileged access |
| singleVirt | input | 1 | Single virtual space mode: privileged lookups skip ASID compare |
| wrEn | input | 1 | Entry write strobe |
| wrVpn | input | 22 | Virtual page number (address bits [31:10]) |
| wrPpn | input | 22 | Physical page number (address bits [31:10]) |
| wrAsid | input | 8 | Entry ASID |
| wrValid | input | 1 | Entry valid flag |
| wrShared | input | 1 | Entry shared across ASIDs |
| wrSize | input | 2 | Page size code |
| wrProt | input | 2 | Permission: bit 1 user access, bit 0 writable |
| wrDirty | input | 1 | Dirty flag |
| wrCacheable | input | 1 | Cacheable attribute |
| wrWriteThru | input | 1 | Write-through attribute |
| invalAll | input | 1 | Clear all valid flags |
| replBound | input | 6 | Replacement counter wrap boundary (0 = full table) |
| replIdx | output | 6 | Replacement counter, slot for the next entry write |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Exactly one entry matched |
| rspIndex | output | 6 | Matching slot |
| rspPaddr | output | 32 | Physical address |
| rspCacheable | output | 1 | Cacheable attribute of the match |
| rspWriteThru | output | 1 | Write-through attribute of the match |
| rspFault | output | 4 | Fault code |

## Verification
The hardest situation to reach is the multi-hit. Writes always land at the replacement counter, so the bench cannot place two overlapping entries directly. Instead it issues a lookup between writes to move the counter, then places a 1 MB page and a 4 KB page inside it under the same ASID. Probes go inside the small page and outside it. The counter wrap is reached by changing `replBound` while the counter sits above it, and by walking the counter up to 63 with the boundary at zero.

// File: rtl/tlbPkg.sv
package tlbPkg;
  localparam int VA_W     = 32;
  localparam int ASID_W   = 8;
  localparam int PAGE_LSB = 10;
  localparam int VPN_W    = VA_W - PAGE_LSB;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accKind_e;

  typedef enum logic [3:0] {
    FLT_NONE     = 4'd0,
    FLT_MISS_RD  = 4'd1,
    FLT_MISS_WR  = 4'd2,
    FLT_MISS_IF  = 4'd3,
    FLT_MULTI    = 4'd4,
    FLT_PROT_RD  = 4'd5,
    FLT_PROT_WR  = 4'd6,
    FLT_PROT_IF  = 4'd7,
    FLT_FIRST_WR = 4'd8
  } fault_e;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [1:0]        sizeCode;
    logic [1:0]        prot;
    logic              dirty;
    logic              cacheable;
    logic              writeThru;
  } tlbEntry_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic lookup;
    logic write;
    logic clearAll;
  } tlbStrobe_t;

  // In-page offset mask for a size code.
  function automatic logic [VA_W-1:0] pageMask(input logic [1:0] sz);
    logic [VA_W-1:0] m;
    case (sz)
      2'd0:    m = (VA_W'(1) << 10) - VA_W'(1);
      2'd1:    m = (VA_W'(1) << 12) - VA_W'(1);
      2'd2:    m = (VA_W'(1) << 16) - VA_W'(1);
      default: m = (VA_W'(1) << 20) - VA_W'(1);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             wrEn,
  input  logic             invalAll,
  input  logic [IDX_W-1:0] replBound,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] replIdx
);
  logic [IDX_W:0]   bumped;
  logic [IDX_W-1:0] nextIdx;

  assign strobe.lookup   = reqValid;
  assign strobe.write    = wrEn && !invalAll;
  assign strobe.clearAll = invalAll;

  // Advance with wrap at software boundary or at the table top.
  always_comb begin
    bumped = {1'b0, replIdx} + 1'b1;
    if ((replBound != '0 && bumped > {1'b0, replBound}) ||
        bumped > (IDX_W+1)'(ENTRIES - 1))
      nextIdx = '0;
    else
      nextIdx = bumped[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              replIdx <= '0;
    else if (strobe.lookup) replIdx <= nextIdx;
  end

  assert_bound_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && replBound != '0 && replIdx == replBound) |=> replIdx == '0);
  assert_top_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && replIdx == IDX_W'(ENTRIES - 1)) |=> replIdx == '0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lookup |=> $stable(replIdx));
endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  tlbEntry_t         wrEntry,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              privMode,
  input  logic              singleVirt,
  output logic              rspValid,
  output logic              rspHit,
  output logic [IDX_W-1:0]  rspIndex,
  output logic [VA_W-1:0]   rspPaddr,
  output logic              rspCacheable,
  output logic              rspWriteThru,
  output logic [3:0]        rspFault
);
  tlbEntry_t        ent [ENTRIES];
  logic [ENTRIES-1:0] hitVec;
  logic             checkAsid;
  logic             anyHit, multiHit;
  logic [IDX_W-1:0] selIdx;
  tlbEntry_t        sel;
  logic [VA_W-1:0]  selMask;
  logic             isWrite, isFetch;
  fault_e           faultNow;
  logic [VA_W-1:0]  paddrNow;

  // Entry storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else if (strobe.clearAll) begin
      for (int i = 0; i < ENTRIES; i++) ent[i].valid <= 1'b0;
    end else if (strobe.write) begin
      ent[wrIdx] <= wrEntry;
    end
  end

  assign checkAsid = !(singleVirt && privMode);

  // Per-entry compare with size-dependent mask
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    logic [VA_W-1:0] inPage;
    logic            addrEq, asidOk;
    assign inPage = pageMask(ent[g].sizeCode);
    assign addrEq = ((reqAddr ^ {ent[g].vpn, {PAGE_LSB{1'b0}}}) & ~inPage) == '0;
    assign asidOk = !checkAsid || ent[g].shared || (ent[g].asid == curAsid);
    assign hitVec[g] = ent[g].valid && addrEq && asidOk;
  end

  // Lowest matching slot and multi-match detect
  always_comb begin
    anyHit   = 1'b0;
    multiHit = 1'b0;
    selIdx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        if (anyHit) multiHit = 1'b1;
        else begin
          anyHit = 1'b1;
          selIdx = IDX_W'(i);
        end
      end
    end
  end

  assign sel     = ent[selIdx];
  assign selMask = pageMask(sel.sizeCode);
  assign isWrite = (reqKind == ACC_WRITE);
  assign isFetch = (reqKind == ACC_FETCH);

  // Fault classification, priority ordered
  always_comb begin
    if (multiHit)
      faultNow = FLT_MULTI;
    else if (!anyHit)
      faultNow = isWrite ? FLT_MISS_WR : (isFetch ? FLT_MISS_IF : FLT_MISS_RD);
    else if (!privMode && !sel.prot[1])
      faultNow = isWrite ? FLT_PROT_WR : (isFetch ? FLT_PROT_IF : FLT_PROT_RD);
    else if (isWrite && !sel.prot[0])
      faultNow = FLT_PROT_WR;
    else if (isWrite && !sel.dirty)
      faultNow = FLT_FIRST_WR;
    else
      faultNow = FLT_NONE;
  end

  assign paddrNow = ({sel.ppn, {PAGE_LSB{1'b0}}} & ~selMask) | (reqAddr & selMask);

  // Registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspHit       <= 1'b0;
      rspIndex     <= '0;
      rspPaddr     <= '0;
      rspCacheable <= 1'b0;
      rspWriteThru <= 1'b0;
      rspFault     <= FLT_NONE;
    end else begin
      rspValid <= strobe.lookup;
      if (strobe.lookup) begin
        rspHit       <= anyHit && !multiHit;
        rspIndex     <= selIdx;
        rspFault     <= faultNow;
        rspPaddr     <= (faultNow == FLT_NONE) ? paddrNow : '0;
        rspCacheable <= (faultNow == FLT_NONE) && sel.cacheable;
        rspWriteThru <= (faultNow == FLT_NONE) && sel.writeThru;
      end
    end
  end

  assert_multi_nohit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == FLT_MULTI) |-> !rspHit);
  assert_miss_nohit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault inside {FLT_MISS_RD, FLT_MISS_WR, FLT_MISS_IF}) |-> !rspHit);
  assert_fault_zero_pa_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != FLT_NONE) |-> (rspPaddr == '0 && !rspCacheable));
  assert_clear_miss_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && $past(strobe.clearAll)) |=> !rspHit);
  assert_rsp_timing_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookup |=> rspValid);
endmodule

// File: rtl/unifiedTlb.sv
module unifiedTlb
  import tlbPkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              privMode,
  input  logic              singleVirt,
  input  logic              wrEn,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [VPN_W-1:0]  wrPpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrValid,
  input  logic              wrShared,
  input  logic [1:0]        wrSize,
  input  logic [1:0]        wrProt,
  input  logic              wrDirty,
  input  logic              wrCacheable,
  input  logic              wrWriteThru,
  input  logic              invalAll,
  input  logic [IDX_W-1:0]  replBound,
  output logic [IDX_W-1:0]  replIdx,
  output logic              rspValid,
  output logic              rspHit,
  output logic [IDX_W-1:0]  rspIndex,
  output logic [VA_W-1:0]   rspPaddr,
  output logic              rspCacheable,
  output logic              rspWriteThru,
  output logic [3:0]        rspFault
);
  tlbStrobe_t strobe;
  tlbEntry_t  wrEntry;

  always_comb begin
    wrEntry.valid     = wrValid;
    wrEntry.shared    = wrShared;
    wrEntry.asid      = wrAsid;
    wrEntry.vpn       = wrVpn;
    wrEntry.ppn       = wrPpn;
    wrEntry.sizeCode  = wrSize;
    wrEntry.prot      = wrProt;
    wrEntry.dirty     = wrDirty;
    wrEntry.cacheable = wrCacheable;
    wrEntry.writeThru = wrWriteThru;
  end

  tlbCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .wrEn      (wrEn),
    .invalAll  (invalAll),
    .replBound (replBound),
    .strobe    (strobe),
    .replIdx   (replIdx)
  );

  tlbDatapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrIdx        (replIdx),
    .wrEntry      (wrEntry),
    .reqAddr      (reqAddr),
    .reqKind      (reqKind),
    .curAsid      (curAsid),
    .privMode     (privMode),
    .singleVirt   (singleVirt),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspIndex     (rspIndex),
    .rspPaddr     (rspPaddr),
    .rspCacheable (rspCacheable),
    .rspWriteThru (rspWriteThru),
    .rspFault     (rspFault)
  );
endmodule

// File: tb/unifiedTlb_tb.sv
`timescale 1ns/1ps
module unifiedTlb_tb;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, IF = 2'd2;

  logic clk = 0, rstN = 0;
  logic reqValid = 0; logic [31:0] reqAddr = 0; logic [1:0] reqKind = 0;
  logic [7:0] curAsid = 0; logic privMode = 0, singleVirt = 0;
  logic wrEn = 0; logic [21:0] wrVpn = 0, wrPpn = 0; logic [7:0] wrAsid = 0;
  logic wrValid = 0, wrShared = 0; logic [1:0] wrSize = 0, wrProt = 0;
  logic wrDirty = 0, wrCacheable = 0, wrWriteThru = 0, invalAll = 0;
  logic [5:0] replBound = 0;
  logic [5:0] replIdx, rspIndex; logic rspValid, rspHit, rspCacheable, rspWriteThru;
  logic [31:0] rspPaddr; logic [3:0] rspFault;

  int nChk = 0, nBad = 0;
  int model = 0;
  int iA, iB, iC, iD, iE, iF, iG, iH;

  always #2.5 clk = ~clk;

  unifiedTlb u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int nextCnt(input int c, input int b);
    int n = c + 1;
    if ((b != 0 && n > b) || n > 63) return 0;
    return n;
  endfunction

  task automatic look(input logic [31:0] a, input logic [1:0] k, input logic [7:0] asid,
                      input logic pv, input logic sv);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqKind = k; curAsid = asid; privMode = pv; singleVirt = sv;
    @(negedge clk);
    reqValid = 0;
    model = nextCnt(model, int'(replBound));
  endtask

  task automatic putEntry(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                          input logic [7:0] asid, input logic sh, input logic [1:0] pr,
                          input logic d, input logic c, input logic wt, output int idx);
    @(negedge clk);
    idx = model;
    chk("R10 write slot equals counter", 32'(replIdx), 32'(model));
    wrEn = 1; wrVpn = va[31:10]; wrPpn = pa[31:10]; wrSize = sz; wrAsid = asid;
    wrShared = sh; wrProt = pr; wrDirty = d; wrCacheable = c; wrWriteThru = wt; wrValid = 1;
    @(negedge clk);
    wrEn = 0;
    look(32'hFFFF_F000, RD, 8'd0, 1'b1, 1'b0); // advance counter, misses
  endtask

  task automatic expectHit(input string req, input int idx, input logic [31:0] pa);
    chk({req, " valid"}, 32'(rspValid), 1);
    chk({req, " hit"}, 32'(rspHit), 1);
    chk({req, " index"}, 32'(rspIndex), 32'(idx));
    chk({req, " paddr"}, rspPaddr, pa);
    chk({req, " fault"}, 32'(rspFault), 0);
  endtask

  task automatic expectFault(input string req, input logic [3:0] f);
    chk({req, " fault"}, 32'(rspFault), 32'(f));
    chk({req, " paddr zero"}, rspPaddr, 0);
  endtask

  task automatic testReset;
    chk("R9 counter reset", 32'(replIdx), 0);
    chk("R12 no response after reset", 32'(rspValid), 0);
    look(32'h1234_5678, RD, 8'd5, 1'b0, 1'b0);
    chk("R5 empty table hit", 32'(rspHit), 0);
    expectFault("R5 empty table read miss", 4'd1);
    chk("R9 counter after one lookup", 32'(replIdx), 1);
  endtask

  task automatic testBasic;
    putEntry(32'h1234_5000, 32'h0ABC_D000, 2'd1, 8'd5, 0, 2'b11, 1, 1, 0, iA);
    look(32'h1234_5678, RD, 8'd5, 1'b0, 1'b0);
    expectHit("R1 R3 R10 4KB hit", iA, 32'h0ABC_D678);
    chk("R12 cacheable", 32'(rspCacheable), 1);
    chk("R12 write-through", 32'(rspWriteThru), 0);
    look(32'h1234_6000, RD, 8'd5, 1'b0, 1'b0);
    expectFault("R1 next page misses", 4'd1);
    look(32'h1234_5678, RD, 8'd6, 1'b0, 1'b0);
    expectFault("R2 ASID mismatch misses", 4'd1);
    look(32'h1234_5678, RD, 8'd6, 1'b1, 1'b1);
    expectHit("R2 single-virtual privileged ignores ASID", iA, 32'h0ABC_D678);
    look(32'h1234_5678, RD, 8'd6, 1'b1, 1'b0);
    expectFault("R2 privileged without single-virtual checks ASID", 4'd1);
    look(32'h1234_5678, RD, 8'd6, 1'b0, 1'b1);
    expectFault("R2 user with single-virtual checks ASID", 4'd1);
  endtask

  task automatic testSizes;
    putEntry(32'h4000_0000, 32'h0023_4C00, 2'd2, 8'd9, 1, 2'b11, 1, 0, 1, iB);
    look(32'h4000_ABCD, RD, 8'd1, 1'b0, 1'b0);
    expectHit("R2 R3 shared 64KB masks PPN", iB, 32'h0023_ABCD);
    chk("R12 write-through attribute", 32'(rspWriteThru), 1);
    putEntry(32'h0000_0400, 32'h7777_7C00, 2'd0, 8'd5, 0, 2'b11, 1, 0, 0, iC);
    look(32'h0000_07FF, IF, 8'd5, 1'b0, 1'b0);
    expectHit("R1 1KB top byte", iC, 32'h7777_7FFF);
    look(32'h0000_0800, IF, 8'd5, 1'b0, 1'b0);
    expectFault("R5 fetch miss", 4'd3);
    look(32'h9000_0000, WR, 8'd5, 1'b0, 1'b0);
    expectFault("R5 write miss", 4'd2);
  endtask

  task automatic testProtection;
    putEntry(32'h2000_0000, 32'h0100_0000, 2'd1, 8'd5, 0, 2'b00, 1, 1, 0, iD);
    look(32'h2000_0010, RD, 8'd5, 1'b0, 1'b0);
    expectFault("R6 user read violation", 4'd5);
    chk("R6 violation still single hit", 32'(rspHit), 1);
    look(32'h2000_0010, WR, 8'd5, 1'b0, 1'b0);
    expectFault("R6 user write violation", 4'd6);
    look(32'h2000_0010, IF, 8'd5, 1'b0, 1'b0);
    expectFault("R6 user fetch violation", 4'd7);
    look(32'h2000_0010, RD, 8'd5, 1'b1, 1'b0);
    expectHit("R6 privileged read allowed", iD, 32'h0100_0010);
    look(32'h2000_0010, WR, 8'd5, 1'b1, 1'b0);
    expectFault("R7 privileged write to read-only", 4'd6);
    putEntry(32'h5000_0000, 32'h0200_0000, 2'd1, 8'd5, 0, 2'b10, 1, 0, 0, iF);
    look(32'h5000_0004, WR, 8'd5, 1'b0, 1'b0);
    expectFault("R7 user write to read-only", 4'd6);
    putEntry(32'h3000_0000, 32'h0400_0000, 2'd3, 8'd5, 0, 2'b11, 0, 0, 0, iE);
    look(32'h300F_FFF0, WR, 8'd5, 1'b0, 1'b0);
    expectFault("R8 first write to clean page", 4'd8);
    look(32'h300F_FFF0, RD, 8'd5, 1'b0, 1'b0);
    expectHit("R8 read of clean page ok", iE, 32'h040F_FFF0);
  endtask

  task automatic testMulti;
    putEntry(32'h6000_0000, 32'h0800_0000, 2'd3, 8'd5, 0, 2'b11, 1, 0, 0, iG);
    putEntry(32'h6002_3000, 32'h0900_0000, 2'd1, 8'd5, 0, 2'b11, 1, 0, 0, iH);
    look(32'h6002_3010, RD, 8'd5, 1'b0, 1'b0);
    expectFault("R4 overlapping pages", 4'd4);
    chk("R4 multi-hit clears hit", 32'(rspHit), 0);
    look(32'h6005_0000, RD, 8'd5, 1'b0, 1'b0);
    expectHit("R4 outside small page single hit", iG, 32'h0805_0000);
  endtask

  task automatic testSameCycle;
    // Lookup and write in the same cycle: lookup sees the old table.
    @(negedge clk);
    wrEn = 1; wrVpn = 22'(32'h7000_0000 >> 10); wrPpn = 22'(32'h0A00_0000 >> 10);
    wrSize = 2'd1; wrAsid = 8'd5; wrShared = 0; wrProt = 2'b11; wrDirty = 1; wrValid = 1;
    reqValid = 1; reqAddr = 32'h7000_0044; reqKind = RD; curAsid = 8'd5; privMode = 0; singleVirt = 0;
    @(negedge clk);
    wrEn = 0; reqValid = 0;
    model = nextCnt(model, int'(replBound));
    expectFault("R12 lookup alongside write sees old table", 4'd1);
    look(32'h7000_0044, RD, 8'd5, 1'b0, 1'b0);
    chk("R12 following lookup sees write", 32'(rspHit), 1);
  endtask

  task automatic testInvalidate;
    @(negedge clk); invalAll = 1;
    @(negedge clk); invalAll = 0;
    look(32'h1234_5678, RD, 8'd5, 1'b0, 1'b0);
    expectFault("R11 entry A gone", 4'd1);
    look(32'h4000_0000, RD, 8'd9, 1'b0, 1'b0);
    expectFault("R11 shared entry gone", 4'd1);
  endtask

  task automatic testCounter;
    @(negedge clk); replBound = 6'd3;
    for (int i = 0; i < 6; i++) begin
      look(32'hFFFF_F000, RD, 8'd0, 1'b1, 1'b0);
      chk("R9 bounded wrap", 32'(replIdx), 32'(model));
    end
    chk("R9 stays within bound", 32'(replIdx <= 6'd3), 1);
    @(negedge clk); replBound = 6'd0;
    for (int i = 0; i < 70 && model != 63; i++) look(32'hFFFF_F000, RD, 8'd0, 1'b1, 1'b0);
    chk("R9 reaches top", 32'(replIdx), 63);
    repeat (3) @(negedge clk);
    chk("R9 holds without lookup", 32'(replIdx), 63);
    look(32'hFFFF_F000, RD, 8'd0, 1'b1, 1'b0);
    chk("R9 wraps past 63", 32'(replIdx), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testBasic();
    testSizes();
    testProtection();
    testMulti();
    testSameCycle();
    testInvalidate();
    testCounter();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule